// File: doc/BRIEF.md
# Pipelined Burst SRAM Access Controller

This block is a synchronous access controller wrapped around a small byte-writable memory array. Every edge samples two active-low address strobes, three chip enables, a global write control, a byte-write enable with four lane selects, a burst-advance control and the address. From these it decides whether the edge starts a new access, ends the current one, or carries on with a burst. Read data passes through a registered output stage. The data bus is driven only when a read result is pending and the asynchronous output enable is low.

The two strobes follow different rules. The processor strobe counts only when the first chip enable is active. Its write controls are sampled one edge after the address, so a processor write takes two cycles. The controller strobe writes in the same edge that captures the address. Once an access has started, cycles without a strobe continue on a two-bit wraparound burst address. That address is either linear or interleaved, chosen by a mode pin.

Top module: `burst_sram_ctrl`

## Requirements
- R1: While reset is applied, and after it is released until the first read, `dout_en` is low and `dout` is zero.
- R2: A read starts at an edge where a valid strobe is low, all three chip enables are active (`sel_a_n`=0, `sel_b`=1, `sel_c_n`=0) and no write lane is enabled. The word at the captured address is on `dout` after the next edge, with `dout_en` high when `out_en_n` is low.
- R3: The processor strobe has no effect while `sel_a_n` is high. When both strobes are low and `sel_a_n` is low, the processor strobe wins, so no controller write happens at that edge.
- R4: At a processor-strobe start edge the write controls and `burst_adv_n` are ignored. At the next edge the write controls and `din` then sampled write the captured address.
- R5: A controller-strobe edge with all chip enables active and a nonzero write-lane set writes `din` at `addr` in that same edge.
- R6: The write-lane set is all four lanes when `wr_all_n`=0. Otherwise, when `wr_byte_n`=0, it is the lanes whose `lane_sel_n[i]` is 0; otherwise it is empty. Lane i is bits 8i+7:8i, and lanes outside the set keep their contents. An edge with an empty set is a read.
- R7: `dout_en` is low whenever `out_en_n` is high, without waiting for a clock edge.
- R8: After any edge that performs a write, `dout_en` is low regardless of `out_en_n`.
- R9: A valid strobe with any chip enable inactive deselects the block. `dout_en` is low after that edge, and later strobe-free cycles do nothing.
- R10: On the first cycle after a start from the deselected state, `dout_en` stays low whatever `out_en_n` is.
- R11: In a strobe-free active cycle, `burst_adv_n`=0 steps the burst count after that cycle's access. The low two address bits are base+n mod 4 when `burst_linear`=1, and base xor n when it is 0; the upper bits stay fixed.
- R12: While active, a strobe-free cycle reads or writes the current burst address according to the write-lane set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Word address |
| proc_strb_n | input | 1 | Processor address strobe, active low |
| ctl_strb_n | input | 1 | Controller address strobe, active low |
| burst_adv_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | First chip enable, active low; gates the processor strobe |
| sel_b | input | 1 | Second chip enable, active high |
| sel_c_n | input | 1 | Third chip enable, active low |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| wr_byte_n | input | 1 | Byte-write enable, active low |
| lane_sel_n | input | 4 | Per-lane write selects, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| burst_linear | input | 1 | 1 linear burst order, 0 interleaved |
| din | input | 32 | Write data |
| dout | output | 32 | Registered read data |
| dout_en | output | 1 | Output drive enable for dout |

## Verification
The bench aims at the strobe conflicts. In one, the processor strobe is blocked by the first chip enable; a design that accepted it would deselect or jump to the new address. In another, both strobes are low; a design that let the controller win would write the word that should survive. It checks that write controls at a processor start edge are ignored and that the following edge performs the write; a design that wrote at the start would leave the first data word in memory. Partial lane writes are read back to catch lanes that get clobbered. A deselect followed by a fresh start checks that stale data is not driven early. Both burst orders are walked past the wrap, which catches a counter that carries into the upper address bits or uses the wrong order.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  localparam int BURST_W = 2;

  typedef struct packed {
    logic start;    // a valid strobe was seen this edge
    logic sel;      // all chip enables active
    logic desel;    // strobe with chip not selected
    logic load;     // new access: capture address
    logic wr;       // this edge writes the array
    logic rd_next;  // a read result is due next edge
    logic advance;  // step the burst count after this edge
  } op_t;
endpackage

// File: rtl/bsram_decode.sv
module bsram_decode
  import bsram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             proc_strb_n,
  input  logic             ctl_strb_n,
  input  logic             burst_adv_n,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             wr_all_n,
  input  logic             wr_byte_n,
  input  logic [LANES-1:0] lane_sel_n,
  input  logic             active,
  output op_t              op,
  output logic [LANES-1:0] wmask
);
  logic             chip_sel, p_go, c_go, any_go, cont, lanes_any, wr_now;
  logic [LANES-1:0] raw_mask;

  always_comb begin
    chip_sel = ~sel_a_n & sel_b & ~sel_c_n;
    p_go     = ~proc_strb_n & ~sel_a_n;
    c_go     = ~ctl_strb_n & ~p_go;
    any_go   = p_go | c_go;
    cont     = ~any_go & active;
    if (!wr_all_n)       raw_mask = '1;
    else if (!wr_byte_n) raw_mask = ~lane_sel_n;
    else                 raw_mask = '0;
    lanes_any = |raw_mask;
    wr_now    = ((c_go & chip_sel) | cont) & lanes_any;
    wmask     = wr_now ? raw_mask : '0;

    op.start   = any_go;
    op.sel     = chip_sel;
    op.desel   = any_go & ~chip_sel;
    op.load    = any_go & chip_sel;
    op.wr      = wr_now;
    op.rd_next = (any_go & chip_sel) ? (p_go | ~lanes_any) : (cont & ~lanes_any);
    op.advance = cont & ~burst_adv_n;
  end
endmodule

// File: rtl/bsram_burst.sv
module bsram_burst #(
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          advance,
  input  logic [BW-1:0] base_in,
  input  logic          linear,
  output logic [BW-1:0] lo_addr
);
  logic [BW-1:0] base_q, base_d, cnt_q, cnt_d;

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    if (load) begin
      base_d = base_in;
      cnt_d  = '0;
    end else if (advance) begin
      cnt_d = cnt_q + 1'b1;
    end
    lo_addr = linear ? (base_q + cnt_q) : (base_q ^ cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
    end
    assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    proc_strb_n,
  input  logic                    ctl_strb_n,
  input  logic                    burst_adv_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    wr_all_n,
  input  logic                    wr_byte_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic                    out_en_n,
  input  logic                    burst_linear,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int HI_W   = ADDR_W - BURST_W;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  op_t               op;
  logic [LANES-1:0]  wmask;
  logic              active_q, active_d;
  logic              rd_pend_q, drive_q, drive_d;
  logic [HI_W-1:0]   hi_q;
  logic [BURST_W-1:0] lo_addr;
  logic [ADDR_W-1:0] cur_addr, waddr;
  logic [DATA_W-1:0] rdata, out_q;

  bsram_decode #(.LANES(LANES)) u_decode (
    .proc_strb_n(proc_strb_n), .ctl_strb_n(ctl_strb_n), .burst_adv_n(burst_adv_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_sel_n(lane_sel_n),
    .active(active_q), .op(op), .wmask(wmask)
  );

  bsram_burst #(.BW(BURST_W)) u_burst (
    .clk(clk), .rst_n(rst_q), .load(op.load), .advance(op.advance),
    .base_in(addr[BURST_W-1:0]), .linear(burst_linear), .lo_addr(lo_addr)
  );

  bsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .we(wmask), .waddr(waddr), .wdata(din),
    .raddr(cur_addr), .rdata(rdata)
  );

  // next state
  always_comb begin
    cur_addr = {hi_q, lo_addr};
    waddr    = op.start ? addr : cur_addr;
    active_d = op.start ? op.sel : active_q;
    drive_d  = rd_pend_q & ~op.wr & ~op.desel;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      active_q  <= 1'b0;
      rd_pend_q <= 1'b0;
      drive_q   <= 1'b0;
    end else begin
      active_q  <= active_d;
      rd_pend_q <= op.rd_next;
      drive_q   <= drive_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)        hi_q <= '0;
    else if (op.load)  hi_q <= addr[ADDR_W-1:BURST_W];
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)         out_q <= '0;
    else if (rd_pend_q) out_q <= rdata;
  end

  assign dout    = out_q;
  assign dout_en = drive_q & ~out_en_n;
endmodule

// File: rtl/burst_sram_ctrl_chk.sv
module burst_sram_ctrl_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_q,
  input logic             proc_strb_n,
  input logic             ctl_strb_n,
  input logic             sel_a_n,
  input logic             sel_b,
  input logic             sel_c_n,
  input logic             wr_all_n,
  input logic             wr_byte_n,
  input logic [LANES-1:0] lane_sel_n,
  input logic             out_en_n,
  input logic             dout_en,
  input logic             active_q
);
  logic             chip_on, p_ok, c_ok, strobe, lanes_on, wr_seen;
  logic [LANES-1:0] lanes;
  logic             launch_q;

  always_comb begin
    chip_on = ~sel_a_n & sel_b & ~sel_c_n;
    p_ok    = ~proc_strb_n & ~sel_a_n;
    c_ok    = ~ctl_strb_n & ~p_ok;
    strobe  = p_ok | c_ok;
    lanes   = !wr_all_n ? '1 : (!wr_byte_n ? ~lane_sel_n : '0);
    lanes_on = |lanes;
    wr_seen = lanes_on & ((c_ok & chip_on) | (~strobe & active_q));
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) launch_q <= 1'b0;
    else        launch_q <= strobe & chip_on & (p_ok | ~lanes_on);
  end

  assert_oe_gate_R7: assert property (@(posedge clk) disable iff (!rst_q)
    out_en_n |-> !dout_en);

  assert_write_off_R8: assert property (@(posedge clk) disable iff (!rst_q)
    wr_seen |=> !dout_en);

  assert_desel_off_R9: assert property (@(posedge clk) disable iff (!rst_q)
    (strobe && !chip_on) |=> !dout_en);

  assert_fresh_off_R10: assert property (@(posedge clk) disable iff (!rst_q)
    (!active_q && strobe && chip_on) |=> !dout_en);

  assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (launch_q && !strobe && !lanes_on) |=> (out_en_n || dout_en));
endmodule

bind burst_sram_ctrl burst_sram_ctrl_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_q(rst_q), .proc_strb_n(proc_strb_n), .ctl_strb_n(ctl_strb_n),
  .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .wr_all_n(wr_all_n),
  .wr_byte_n(wr_byte_n), .lane_sel_n(lane_sel_n), .out_en_n(out_en_n),
  .dout_en(dout_en), .active_q(active_q)
);

// File: tb/burst_sram_ctrl_bench.sv
`timescale 1ns/1ps
module burst_sram_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  addr;
  logic        proc_strb_n, ctl_strb_n, burst_adv_n;
  logic        sel_a_n, sel_b, sel_c_n;
  logic        wr_all_n, wr_byte_n, out_en_n, burst_linear;
  logic [3:0]  lane_sel_n;
  logic [31:0] din, dout;
  logic        dout_en;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  burst_sram_ctrl u_burst_sram_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .proc_strb_n(proc_strb_n),
    .ctl_strb_n(ctl_strb_n), .burst_adv_n(burst_adv_n), .sel_a_n(sel_a_n),
    .sel_b(sel_b), .sel_c_n(sel_c_n), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
    .lane_sel_n(lane_sel_n), .out_en_n(out_en_n), .burst_linear(burst_linear),
    .din(din), .dout(dout), .dout_en(dout_en)
  );

  // reference model state
  logic [31:0] m_mem [16];
  logic        m_active, m_rdpend, m_drive;
  logic [31:0] m_out;
  logic [1:0]  m_hi, m_base, m_cnt;

  function automatic logic [31:0] pat(input int a);
    return 32'hA5A5_0000 | (32'(a) * 32'h0000_0101);
  endfunction

  function automatic logic [1:0] seq_lo(input logic [1:0] b, input int n, input logic lin);
    return lin ? 2'(b + 2'(n)) : (b ^ 2'(n));
  endfunction

  task automatic model_reset();
    m_active = 0; m_rdpend = 0; m_drive = 0; m_out = '0;
    m_hi = 0; m_base = 0; m_cnt = 0;
  endtask

  task automatic model_step();
    logic sel, pgo, cgo, st, cont, wr, nd;
    logic [3:0] mask, cur, wa;
    logic [31:0] no;
    sel  = !sel_a_n && sel_b && !sel_c_n;
    pgo  = !proc_strb_n && !sel_a_n;
    cgo  = !ctl_strb_n && !pgo;
    st   = pgo || cgo;
    mask = !wr_all_n ? 4'hF : (!wr_byte_n ? ~lane_sel_n : 4'h0);
    cont = !st && m_active;
    cur  = {m_hi, seq_lo(m_base, int'(m_cnt), burst_linear)};
    wr   = ((cgo && sel) || cont) && (mask != 0);
    wa   = st ? addr : cur;
    nd   = m_rdpend && !wr && !(st && !sel);
    no   = m_rdpend ? m_mem[cur] : m_out;
    if (wr) for (int i = 0; i < 4; i++) if (mask[i]) m_mem[wa][i*8 +: 8] = din[i*8 +: 8];
    if (st && sel) begin
      m_rdpend = pgo || (mask == 0);
      m_hi = addr[3:2]; m_base = addr[1:0]; m_cnt = 0;
    end else if (cont) begin
      m_rdpend = (mask == 0);
      if (!burst_adv_n) m_cnt = m_cnt + 1;
    end else m_rdpend = 0;
    if (st) m_active = sel;
    m_drive = nd; m_out = no;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_outputs(input string tag);
    chk(tag, {31'd0, dout_en}, {31'd0, m_drive && !out_en_n});
    if (m_drive && !out_en_n) chk(tag, dout, m_out);
  endtask

  task automatic tick(input string tag);
    model_step();
    @(negedge clk);
    check_outputs(tag);
  endtask

  task automatic idle();
    proc_strb_n = 1; ctl_strb_n = 1; burst_adv_n = 1;
    sel_a_n = 0; sel_b = 1; sel_c_n = 0;
    wr_all_n = 1; wr_byte_n = 1; lane_sel_n = 4'hF; out_en_n = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL R12 watchdog: cycles %0d expected below %0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle(); burst_linear = 1; addr = 0; din = 0; rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset dout_en", {31'd0, dout_en}, 32'd0);
    chk("R1 reset dout", dout, 32'd0);
    rst_n = 1;
    repeat (4) tick("R1");
    chk("R1 after release", {31'd0, dout_en}, 32'd0);

    // fill the array with controller-strobe global writes
    for (int a = 0; a < 16; a++) begin
      ctl_strb_n = 0; wr_all_n = 0; addr = 4'(a); din = pat(a);
      tick("R5 fill");
    end
    idle(); tick("R8");

    // plain read with one-edge latency
    ctl_strb_n = 0; addr = 4'd5; tick("R2");
    idle(); tick("R2");
    chk("R2 read data", dout, pat(5));
    chk("R2 read drive", {31'd0, dout_en}, 32'd1);

    // partial lane write: lanes 0 and 2
    ctl_strb_n = 0; wr_byte_n = 0; lane_sel_n = 4'b1010; addr = 4'd3; din = 32'hAABBCCDD;
    tick("R6");
    idle(); ctl_strb_n = 0; addr = 4'd3; tick("R6");
    idle(); tick("R6");
    chk("R6 lane write", dout, {pat(3)[31:24], 8'hBB, pat(3)[15:8], 8'hDD});

    // global write overrides lane selects
    ctl_strb_n = 0; wr_all_n = 0; wr_byte_n = 0; lane_sel_n = 4'hF; addr = 4'd9; din = 32'h1234_5678;
    tick("R6");
    idle(); ctl_strb_n = 0; addr = 4'd9; tick("R6");
    idle(); tick("R6");
    chk("R6 global write", dout, 32'h1234_5678);

    // processor write: controls ignored at start, used one edge later
    proc_strb_n = 0; wr_all_n = 0; addr = 4'd7; din = 32'hDEAD_0001;
    tick("R4");
    idle(); wr_all_n = 0; din = 32'hBEEF_0002;
    tick("R8");
    chk("R8 write tristate", {31'd0, dout_en}, 32'd0);
    idle(); ctl_strb_n = 0; addr = 4'd7; tick("R4");
    idle(); tick("R4");
    chk("R4 second-edge write", dout, 32'hBEEF_0002);

    // processor strobe blocked by first chip enable
    proc_strb_n = 0; sel_a_n = 1; addr = 4'd2; tick("R3");
    idle(); tick("R3");
    chk("R3 blocked strobe", dout, 32'hBEEF_0002);
    // both strobes low: processor wins, no controller write
    proc_strb_n = 0; ctl_strb_n = 0; wr_all_n = 0; addr = 4'd11; din = 32'hFFFF_0000;
    tick("R3");
    idle(); tick("R3");
    chk("R3 priority", dout, pat(11));

    // deselect, then fresh start
    ctl_strb_n = 0; sel_b = 0; tick("R9");
    chk("R9 deselect", {31'd0, dout_en}, 32'd0);
    idle(); tick("R9");
    chk("R9 stays off", {31'd0, dout_en}, 32'd0);
    ctl_strb_n = 0; addr = 4'd0; tick("R10");
    chk("R10 fresh cycle", {31'd0, dout_en}, 32'd0);
    idle(); tick("R10");
    chk("R10 then data", dout, pat(0));

    // asynchronous output enable
    out_en_n = 1; tick("R7");
    chk("R7 oe high", {31'd0, dout_en}, 32'd0);
    #1 out_en_n = 0; #0.5;
    chk("R7 oe low async", {31'd0, dout_en}, 32'd1);

    // bursts in both orders, past the wrap
    for (int mode = 1; mode >= 0; mode--) begin
      logic [3:0] b;
      b = mode ? 4'b0110 : 4'b1001;
      burst_linear = mode[0];
      idle(); proc_strb_n = 0; addr = b; tick("R11");
      idle(); burst_adv_n = 0;
      for (int n = 0; n < 5; n++) begin
        tick("R11");
        chk(mode ? "R11 linear" : "R11 interleaved", dout,
            m_mem[{b[3:2], seq_lo(b[1:0], n, mode[0])}]);
      end
    end
    idle(); tick("R12");

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      proc_strb_n = ($urandom % 100) >= 20;
      ctl_strb_n  = ($urandom % 100) >= 25;
      burst_adv_n = $urandom % 2;
      sel_a_n     = ($urandom % 100) < 8;
      sel_b       = ($urandom % 100) >= 6;
      sel_c_n     = ($urandom % 100) < 6;
      wr_all_n    = ($urandom % 100) >= 15;
      wr_byte_n   = ($urandom % 100) >= 30;
      lane_sel_n  = 4'($urandom);
      out_en_n    = ($urandom % 100) < 15;
      burst_linear = ($urandom % 100) < 50;
      addr = 4'($urandom);
      din  = $urandom;
      tick("R12");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule